// File: doc/BRIEF.md
# Counter-Type ADC Controller

This block is the digital half of a counter-based analog-to-digital converter. It drives the input word of an external DAC and reads one comparator bit that goes high when the DAC voltage is above the held analog input. The DAC, the comparator and the sample-and-hold stage sit outside the block. The block latches a result code and flags it as valid.

Two modes are available. A start pulse taken while the block is idle also samples the mode input. In staircase mode the counter clears to zero and climbs one code per clock. It stops on the first cycle where the comparator reports the DAC above the input. The code on the DAC in that cycle is latched, with a one-cycle done pulse. If the counter reaches full scale without a comparator change, full scale is latched. In tracking mode the counter also starts from zero and then runs freely. It steps up while the DAC is not above the input and steps down while it is, and it saturates at both ends of the range. The result register follows the counter every clock. A second start pulse stops tracking.

The converter width is a parameter, 8 bits by default. A staircase conversion of an n-bit converter takes at most 2^n cycles.

Top module: `adcCounterCtl`

## Requirements
- R1: After reset, dacCode, resultCode, resultValid, busy and donePulse are all 0.
- R2: A startPulse sampled while idle with modeTrack=0 begins a staircase conversion. After that edge, dacCode is 0, busy is 1 and resultValid is 0. dacCode then rises by exactly 1 per cycle while cmpHigh is 0.
- R3: On the first staircase cycle where cmpHigh is 1, the current dacCode k is latched into resultCode. donePulse and resultValid go high and busy goes low, all after the (k+1)-th rising edge counted from the edge that sampled the start.
- R4: If a staircase conversion reaches dacCode = 2^WIDTH-1 with cmpHigh still 0, full scale is latched on the next edge. The conversion therefore never exceeds 2^WIDTH cycles.
- R5: donePulse lasts exactly one cycle. While idle, resultCode and resultValid hold their values until the next start.
- R6: During a staircase conversion, startPulse and modeTrack are ignored: neither the result nor the latency changes.
- R7: A startPulse sampled while idle with modeTrack=1 enters tracking with dacCode cleared to 0 and busy high. Each following cycle, dacCode steps +1 when cmpHigh is 0 and -1 when cmpHigh is 1.
- R8: In tracking, dacCode saturates: it stays at 2^WIDTH-1 when cmpHigh is 0 there, and stays at 0 when cmpHigh is 1 there.
- R9: In each tracking cycle, resultCode takes the dacCode of the previous cycle and resultValid is 1. donePulse stays 0.
- R10: A startPulse during tracking returns the block to idle: busy falls, and dacCode and resultCode hold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous active-low reset |
| startPulse | input | 1 | Starts a conversion when idle; stops tracking |
| modeTrack | input | 1 | Mode sampled at start: 0 staircase, 1 tracking |
| cmpHigh | input | 1 | Comparator: 1 when DAC output is above held input |
| dacCode | output | WIDTH | Counter value driving the DAC |
| resultCode | output | WIDTH | Latched conversion result |
| resultValid | output | 1 | resultCode holds a valid conversion |
| busy | output | 1 | Conversion or tracking in progress |
| donePulse | output | 1 | One-cycle pulse when a staircase result latches |

## Verification
The bench runs staircase conversions over every input level of a 6-bit configuration. It also uses levels above full scale and below zero, and compares each result and each latency against the closed-form value. This catches an off-by-one in the latch, which would shift every code or every latency by one, and a missing full-scale stop, which would let the counter wrap to zero and hang. A disturbed conversion pulses start and flips the mode mid-ramp; a design that restarts or re-reads the mode would change the latency. In tracking, each cycle is checked against the expected ±1 step. The input is then parked beyond both rails to expose a counter that wraps instead of saturating. The stop pulse checks that the code and result freeze.

// File: rtl/adcCtlPkg.sv
package adcCtlPkg;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_RAMP  = 2'd1,
    ST_TRACK = 2'd2
  } adcStateT;

  // Strobes issued by control to the datapath each cycle
  typedef struct packed {
    logic clearCount;
    logic countUp;
    logic countDown;
    logic latchCount;
    logic setValid;
    logic clrValid;
  } adcCtlT;

endpackage

// File: rtl/adcCtlDatapath.sv
module adcCtlDatapath
  import adcCtlPkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  adcCtlT           ctl,
  output logic [WIDTH-1:0] dacCode,
  output logic [WIDTH-1:0] resultCode,
  output logic             resultValid,
  output logic             atMax,
  output logic             atZero
);

  localparam logic [WIDTH-1:0] MAX_CODE = '1;

  logic [WIDTH-1:0] countQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      countQ <= '0;
    end else if (ctl.clearCount) begin
      countQ <= '0;
    end else if (ctl.countUp) begin
      countQ <= countQ + 1'b1;
    end else if (ctl.countDown) begin
      countQ <= countQ - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      resultCode  <= '0;
      resultValid <= 1'b0;
    end else begin
      if (ctl.latchCount) begin
        resultCode <= countQ;
      end
      if (ctl.clrValid) begin
        resultValid <= 1'b0;
      end else if (ctl.setValid) begin
        resultValid <= 1'b1;
      end
    end
  end

  assign dacCode = countQ;
  assign atMax   = (countQ == MAX_CODE);
  assign atZero  = (countQ == '0);

endmodule

// File: rtl/adcCtlControl.sv
module adcCtlControl
  import adcCtlPkg::*;
(
  input  logic   clk,
  input  logic   rstN,
  input  logic   startPulse,
  input  logic   modeTrack,
  input  logic   cmpHigh,
  input  logic   atMax,
  input  logic   atZero,
  output adcCtlT ctl,
  output logic   busy,
  output logic   trackActive,
  output logic   donePulse
);

  adcStateT stateQ, stateD;
  logic     doneD;

  always_comb begin
    stateD = stateQ;
    ctl    = '0;
    doneD  = 1'b0;
    unique case (stateQ)
      ST_IDLE: begin
        if (startPulse) begin
          ctl.clearCount = 1'b1;
          ctl.clrValid   = 1'b1;
          stateD         = modeTrack ? ST_TRACK : ST_RAMP;
        end
      end
      ST_RAMP: begin
        if (cmpHigh || atMax) begin
          ctl.latchCount = 1'b1;
          ctl.setValid   = 1'b1;
          doneD          = 1'b1;
          stateD         = ST_IDLE;
        end else begin
          ctl.countUp = 1'b1;
        end
      end
      ST_TRACK: begin
        if (startPulse) begin
          stateD = ST_IDLE;
        end else begin
          ctl.latchCount = 1'b1;
          ctl.setValid   = 1'b1;
          if (cmpHigh && !atZero) begin
            ctl.countDown = 1'b1;
          end else if (!cmpHigh && !atMax) begin
            ctl.countUp = 1'b1;
          end
        end
      end
      default: stateD = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      stateQ    <= ST_IDLE;
      donePulse <= 1'b0;
    end else begin
      stateQ    <= stateD;
      donePulse <= doneD;
    end
  end

  assign busy        = (stateQ != ST_IDLE);
  assign trackActive = (stateQ == ST_TRACK);

endmodule

// File: rtl/adcCounterCtl.sv
module adcCounterCtl
  import adcCtlPkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             startPulse,
  input  logic             modeTrack,
  input  logic             cmpHigh,
  output logic [WIDTH-1:0] dacCode,
  output logic [WIDTH-1:0] resultCode,
  output logic             resultValid,
  output logic             busy,
  output logic             donePulse
);

  adcCtlT ctl;
  logic   atMax;
  logic   atZero;
  logic   trackActive;

  adcCtlControl u_control (
    .clk        (clk),
    .rstN       (rstN),
    .startPulse (startPulse),
    .modeTrack  (modeTrack),
    .cmpHigh    (cmpHigh),
    .atMax      (atMax),
    .atZero     (atZero),
    .ctl        (ctl),
    .busy       (busy),
    .trackActive(trackActive),
    .donePulse  (donePulse)
  );

  adcCtlDatapath #(.WIDTH(WIDTH)) u_datapath (
    .clk        (clk),
    .rstN       (rstN),
    .ctl        (ctl),
    .dacCode    (dacCode),
    .resultCode (resultCode),
    .resultValid(resultValid),
    .atMax      (atMax),
    .atZero     (atZero)
  );

endmodule

// File: rtl/adcCounterCtlChecker.sv
module adcCounterCtlChecker #(
  parameter int WIDTH = 8
) (
  input logic             clk,
  input logic             rstN,
  input logic             startPulse,
  input logic             cmpHigh,
  input logic [WIDTH-1:0] dacCode,
  input logic [WIDTH-1:0] resultCode,
  input logic             resultValid,
  input logic             busy,
  input logic             donePulse,
  input logic             trackActive
);

  localparam logic [WIDTH-1:0] MAX_CODE = '1;

  logic inRamp, inTrack;
  assign inRamp  = busy && !trackActive;
  assign inTrack = busy && trackActive;

  a_r2_ramp_step: assert property (@(posedge clk) disable iff (!rstN)
    (inRamp && !cmpHigh && dacCode != MAX_CODE) |=>
      (dacCode == WIDTH'($past(dacCode) + 1'b1)) && busy);

  a_r3_latch_cross: assert property (@(posedge clk) disable iff (!rstN)
    (inRamp && cmpHigh) |=>
      donePulse && !busy && resultValid && (resultCode == $past(dacCode)));

  a_r4_full_scale: assert property (@(posedge clk) disable iff (!rstN)
    (inRamp && dacCode == MAX_CODE) |=> donePulse && (resultCode == MAX_CODE));

  a_r5_done_once: assert property (@(posedge clk) disable iff (!rstN)
    donePulse |=> !donePulse);

  a_r5_idle_hold: assert property (@(posedge clk) disable iff (!rstN)
    (!busy && !startPulse) |=> $stable(resultCode) && $stable(resultValid));

  a_r7_track_up: assert property (@(posedge clk) disable iff (!rstN)
    (inTrack && !startPulse && !cmpHigh && dacCode != MAX_CODE) |=>
      dacCode == WIDTH'($past(dacCode) + 1'b1));

  a_r7_track_down: assert property (@(posedge clk) disable iff (!rstN)
    (inTrack && !startPulse && cmpHigh && dacCode != '0) |=>
      dacCode == WIDTH'($past(dacCode) - 1'b1));

  a_r8_sat_top: assert property (@(posedge clk) disable iff (!rstN)
    (inTrack && !startPulse && !cmpHigh && dacCode == MAX_CODE) |=>
      dacCode == MAX_CODE);

  a_r8_sat_bottom: assert property (@(posedge clk) disable iff (!rstN)
    (inTrack && !startPulse && cmpHigh && dacCode == '0) |=> dacCode == '0);

  a_r9_track_result: assert property (@(posedge clk) disable iff (!rstN)
    (inTrack && !startPulse) |=>
      resultValid && !donePulse && (resultCode == $past(dacCode)));

  a_r10_track_stop: assert property (@(posedge clk) disable iff (!rstN)
    (inTrack && startPulse) |=>
      !busy && $stable(dacCode) && $stable(resultCode));

endmodule

bind adcCounterCtl adcCounterCtlChecker #(.WIDTH(WIDTH)) u_checker (
  .clk        (clk),
  .rstN       (rstN),
  .startPulse (startPulse),
  .cmpHigh    (cmpHigh),
  .dacCode    (dacCode),
  .resultCode (resultCode),
  .resultValid(resultValid),
  .busy       (busy),
  .donePulse  (donePulse),
  .trackActive(trackActive)
);

// File: tb/adcCounterCtl_bench.sv
module adcCounterCtl_bench;

  localparam int WIDTH = 6;
  localparam int MAXV  = (1 << WIDTH) - 1;

  logic             clk = 1'b0;
  logic             rstN = 1'b0;
  logic             startPulse = 1'b0;
  logic             modeTrack = 1'b0;
  logic             cmpHigh;
  logic [WIDTH-1:0] dacCode;
  logic [WIDTH-1:0] resultCode;
  logic             resultValid;
  logic             busy;
  logic             donePulse;

  int vin = 0;
  int compared = 0;
  int mismatched = 0;
  int cycles = 0;

  always #2 clk = ~clk;
  always @(posedge clk) cycles <= cycles + 1;

  // Analog model: DAC voltage above held input
  assign cmpHigh = (int'(dacCode) > vin);

  adcCounterCtl #(.WIDTH(WIDTH)) u_adcCounterCtl (
    .clk(clk), .rstN(rstN), .startPulse(startPulse), .modeTrack(modeTrack),
    .cmpHigh(cmpHigh), .dacCode(dacCode), .resultCode(resultCode),
    .resultValid(resultValid), .busy(busy), .donePulse(donePulse)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    compared++;
    if (!ok) begin
      mismatched++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic finishRun();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  endtask

  // One staircase conversion; disturb pulses start and flips mode mid-ramp (R6)
  task automatic runStair(input int v, input bit disturb);
    int expK, n;
    expK = (v < MAXV) ? ((v < 0) ? 0 : v + 1) : MAXV;
    @(negedge clk);
    vin = v;
    modeTrack = 1'b0;
    startPulse = 1'b1;
    @(posedge clk);
    @(negedge clk);
    startPulse = 1'b0;
    check(dacCode == 0, "R2 cleared code", int'(dacCode), 0);
    check(busy == 1'b1, "R2 busy", int'(busy), 1);
    check(resultValid == 1'b0, "R2 valid cleared", int'(resultValid), 0);
    n = 0;
    while (1) begin
      if (disturb && n == 3) begin
        startPulse = 1'b1;
        modeTrack = 1'b1;
      end
      @(posedge clk);
      n++;
      @(negedge clk);
      startPulse = 1'b0;
      modeTrack = 1'b0;
      if (donePulse) break;
      if (n > 2 * (MAXV + 2)) begin
        check(1'b0, "R4 no completion", n, expK + 1);
        return;
      end
      if (n <= expK) check(int'(dacCode) == n, "R2 ramp step", int'(dacCode), n);
    end
    check(n == expK + 1, disturb ? "R6 latency" : (v >= MAXV ? "R4 latency" : "R3 latency"), n, expK + 1);
    check(int'(resultCode) == expK, disturb ? "R6 result" : (v >= MAXV ? "R4 result" : "R3 result"),
          int'(resultCode), expK);
    check(!busy && resultValid, "R3 busy low valid high", int'({busy, resultValid}), 1);
    @(negedge clk);
    vin = MAXV - v;
    check(donePulse == 1'b0, "R5 done one cycle", int'(donePulse), 0);
    repeat (2) @(negedge clk);
    check(int'(resultCode) == expK && resultValid, "R5 idle hold", int'(resultCode), expK);
  endtask

  // Tracking for a number of cycles with a fixed input level
  task automatic trackFor(input int v, input int count, input string req);
    int prev, expNext;
    vin = v;
    for (int i = 0; i < count; i++) begin
      prev = int'(dacCode);
      if (prev > v) expNext = (prev == 0) ? 0 : prev - 1;
      else expNext = (prev == MAXV) ? MAXV : prev + 1;
      @(posedge clk);
      @(negedge clk);
      check(int'(dacCode) == expNext, req, int'(dacCode), expNext);
      check(int'(resultCode) == prev && resultValid, "R9 result follows", int'(resultCode), prev);
      check(donePulse == 1'b0, "R9 no done", int'(donePulse), 0);
    end
  endtask

  initial begin
    while (cycles < 150000) @(posedge clk);
    check(1'b0, "watchdog", cycles, 0);
    finishRun();
  end

  initial begin
    int holdCode, holdRes;
    repeat (3) @(negedge clk);
    check(dacCode == 0 && resultCode == 0, "R1 reset codes", int'(resultCode), 0);
    check(!resultValid && !busy && !donePulse, "R1 reset flags",
          int'({resultValid, busy, donePulse}), 0);
    rstN = 1'b1;
    @(negedge clk);

    for (int v = 0; v <= MAXV; v++) runStair(v, 1'b0);
    runStair(MAXV + 10, 1'b0);
    runStair(20, 1'b1);
    runStair(0, 1'b1);

    // Tracking mode
    @(negedge clk);
    vin = 30;
    modeTrack = 1'b1;
    startPulse = 1'b1;
    @(posedge clk);
    @(negedge clk);
    startPulse = 1'b0;
    modeTrack = 1'b0;
    check(dacCode == 0 && busy, "R7 track entry", int'(dacCode), 0);
    trackFor(30, 45, "R7 track to 30");
    trackFor(10, 40, "R7 track down to 10");
    trackFor(MAXV, 80, "R8 top saturation");
    check(int'(dacCode) == MAXV, "R8 parked at top", int'(dacCode), MAXV);
    trackFor(-1, 80, "R8 bottom saturation");
    check(dacCode == 0, "R8 parked at zero", int'(dacCode), 0);
    trackFor(25, 12, "R7 climb again");

    // Stop tracking
    holdCode = int'(dacCode);
    holdRes = int'(resultCode);
    startPulse = 1'b1;
    @(posedge clk);
    @(negedge clk);
    startPulse = 1'b0;
    check(busy == 1'b0, "R10 busy falls", int'(busy), 0);
    vin = 3;
    repeat (4) @(negedge clk);
    check(int'(dacCode) == holdCode, "R10 code held", int'(dacCode), holdCode);
    check(int'(resultCode) == holdRes, "R10 result held", int'(resultCode), holdRes);

    runStair(7, 1'b0);
    finishRun();
  end

endmodule